// File: doc/BRIEF.md
# DAC Sample Deinterleaver and DDR Formatter

This block sits on the host side of a link to a high-speed DAC that takes its data over two double-data-rate ports. It runs in a core clock domain at one quarter of the DAC sample rate. In each core cycle it takes four consecutive samples and splits them into two streams. Even-indexed samples go to port 0 and odd-indexed samples go to port 1. For each port it produces one word for the rising clock edge and one word for the falling clock edge. A DDR output stage placed after the block serialises each pair of words onto the wire.

The forwarded data clock is not generated as a separate clock. It comes out as one extra data lane that carries a rising-edge bit and a falling-edge bit. That lane goes through the same output path as the data, so its edges line up with the data transitions. The DAC expects offset binary. A configuration input selects whether incoming samples are two's complement, in which case the block inverts only the most significant bit, or already offset binary, in which case they pass through unchanged.

While the input is not valid, or while reset is held, the data words carry the mid-scale code so that the analogue output stays quiet. The clock lane keeps its alternating pattern at all times, so the receiver's delay-lock loop can acquire lock before any data arrives.

Top module: `dac_ddr_fmt`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four data words take the mid-scale code after that edge. The mid-scale code has the MSB set and all other bits clear, which is 0x2000 for the default width of 14.
- R2: Samples are packed in `in_samples` with sample i at bits [i*W +: W]. A valid cycle maps sample 0 to `p0_rise`, sample 1 to `p1_rise`, sample 2 to `p0_fall` and sample 3 to `p1_fall`.
- R3: Every output is registered. Inputs sampled at one rising clock edge appear on the outputs right after that same edge, and the outputs then hold until the next edge.
- R4: When `cfg_twos` is 1, each output word is its sample with only the MSB inverted, so two's complement becomes offset binary (for example 0x2000 maps to 0x0000 and 0x1FFF maps to 0x3FFF).
- R5: When `cfg_twos` is 0, each valid sample reaches its output word unchanged.
- R6: When `in_valid` is 0 at an edge, all four data words become mid-scale, whatever the values of `in_samples` and `cfg_twos`.
- R7: The clock lane gives `clk_rise` = 1 and `clk_fall` = 0 after every clock edge, including edges during reset. The lane therefore toggles once per half period of the core clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one quarter of the DAC sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Qualifies `in_samples` in this cycle |
| cfg_twos | input | 1 | 1: inputs are two's complement, so the MSB is inverted; 0: inputs pass through |
| in_samples | input | 4*W | Four consecutive samples, with sample 0 in the low bits |
| p0_rise | output | W | Port 0 rising-edge word (sample 0) |
| p0_fall | output | W | Port 0 falling-edge word (sample 2) |
| p1_rise | output | W | Port 1 rising-edge word (sample 1) |
| p1_fall | output | W | Port 1 falling-edge word (sample 3) |
| clk_rise | output | 1 | Clock lane bit for the rising edge |
| clk_fall | output | 1 | Clock lane bit for the falling edge |

## Verification
Random runs draw four independent samples per cycle, so a swap of any two of the four sample positions between ports or edges shows up on the outputs. Valid, format and reset are toggled randomly. This separates the idle mid-scale path and the reset path from the MSB conversion. Directed cases use all zeros, all ones, the most negative code and the most positive code, with conversion both on and off. These show that only the top bit is inverted and that mid-scale does not depend on the format setting. The clock lane is compared on every cycle, including cycles in reset.

// File: rtl/dfmt_pkg.sv
// Package: dfmt_pkg
// Holds the constants and the format type that the deinterleaver shares.
// Assumes four samples per core cycle and two DDR ports.
package dfmt_pkg;
    localparam int SMP_PER_CYC = 4;
    localparam int NUM_PORTS   = 2;

    typedef enum logic {
        FMT_OFFSET = 1'b0,
        FMT_TWOS   = 1'b1
    } smp_fmt_e;
endpackage

// File: rtl/dfmt_conv.sv
// Module: dfmt_conv
// Converts one sample to offset binary. When the format is two's
// complement it inverts the MSB. All lower bits pass through unchanged.
// Assumes W >= 2. The module is purely combinational.
module dfmt_conv
    import dfmt_pkg::*;
#(
    parameter int W = 14
) (
    input  logic [W-1:0] raw,
    input  smp_fmt_e     fmt,
    output logic [W-1:0] ob
);
    // Invert the top bit only when the source is two's complement.
    always_comb begin
        ob        = raw;
        ob[W-1]   = raw[W-1] ^ (fmt == FMT_TWOS);
    end
endmodule

// File: rtl/dfmt_port.sv
// Module: dfmt_port
// Registers the rising-edge and falling-edge words for one DDR port.
// In reset, or when the input is not valid, both words are loaded with
// the mid-scale code. Assumes the inputs have already been converted to
// offset binary.
module dfmt_port #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld,
    input  logic [W-1:0] rise_d,
    input  logic [W-1:0] fall_d,
    output logic [W-1:0] rise_q,
    output logic [W-1:0] fall_q
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    // Load the word pair, or mid-scale while in reset or idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !vld) begin
            rise_q <= MID;
            fall_q <= MID;
        end else begin
            rise_q <= rise_d;
            fall_q <= fall_d;
        end
    end
endmodule

// File: rtl/dfmt_clk_lane.sv
// Module: dfmt_clk_lane
// Drives the forwarded clock as a data lane: rising word 1, falling word 0.
// Reset loads the same pattern, so the lane never stops toggling.
// The lane is registered so that it has the same latency as the data ports.
module dfmt_clk_lane (
    input  logic clk,
    input  logic rst_n,
    output logic lane_rise,
    output logic lane_fall
);
    // Hold the alternating pattern both in reset and in normal operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_rise <= 1'b1;
            lane_fall <= 1'b0;
        end else begin
            lane_rise <= 1'b1;
            lane_fall <= 1'b0;
        end
    end
endmodule

// File: rtl/dac_ddr_fmt.sv
// Module: dac_ddr_fmt
// Top level. Converts four samples per cycle to offset binary, splits them
// into even and odd ports, and registers the rising and falling words of
// each port together with the in-band clock lane. Assumes the DDR output
// primitives sit after this block. Latency is one cycle.
module dac_ddr_fmt
    import dfmt_pkg::*;
#(
    parameter int W = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     cfg_twos,
    input  logic [SMP_PER_CYC*W-1:0] in_samples,
    output logic [W-1:0]             p0_rise,
    output logic [W-1:0]             p0_fall,
    output logic [W-1:0]             p1_rise,
    output logic [W-1:0]             p1_fall,
    output logic                     clk_rise,
    output logic                     clk_fall
);
    smp_fmt_e     fmt;
    logic [W-1:0] conv  [SMP_PER_CYC];
    logic [W-1:0] rise_w[NUM_PORTS];
    logic [W-1:0] fall_w[NUM_PORTS];

    // Decode the format configuration bit.
    always_comb fmt = cfg_twos ? FMT_TWOS : FMT_OFFSET;

    // Convert each sample lane.
    for (genvar i = 0; i < SMP_PER_CYC; i++) begin : g_conv
        dfmt_conv #(.W(W)) u_conv (
            .raw (in_samples[i*W +: W]),
            .fmt (fmt),
            .ob  (conv[i])
        );
    end

    // Port p: the rising word takes sample p, the falling word takes sample p+NUM_PORTS.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dfmt_port #(.W(W)) u_port (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (in_valid),
            .rise_d (conv[p]),
            .fall_d (conv[p+NUM_PORTS]),
            .rise_q (rise_w[p]),
            .fall_q (fall_w[p])
        );
    end

    dfmt_clk_lane u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .lane_rise (clk_rise),
        .lane_fall (clk_fall)
    );

    assign p0_rise = rise_w[0];
    assign p0_fall = fall_w[0];
    assign p1_rise = rise_w[1];
    assign p1_fall = fall_w[1];
endmodule

// File: rtl/dfmt_chk.sv
// Module: dfmt_chk
// Checker for dac_ddr_fmt. It relates the outputs to the inputs of the
// previous edge. It is attached to the top module with the bind at the end
// of this file.
module dfmt_chk #(
    parameter int W = 14
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic           cfg_twos,
    input logic [4*W-1:0] in_samples,
    input logic [W-1:0]   p0_rise,
    input logic [W-1:0]   p0_fall,
    input logic [W-1:0]   p1_rise,
    input logic [W-1:0]   p1_fall,
    input logic           clk_rise,
    input logic           clk_fall
);
    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
    logic init_done = 1'b0;

    // Marks that at least one edge has been seen.
    always_ff @(posedge clk) init_done <= 1'b1;

    AST_RESET_MID: assert property (@(posedge clk) disable iff (!init_done)
        !rst_n |=> (p0_rise == MID && p0_fall == MID && p1_rise == MID && p1_fall == MID)); // R1

    AST_PASS_MAP: assert property (@(posedge clk) disable iff (!rst_n || !init_done)
        ($past(rst_n) && $past(in_valid) && !$past(cfg_twos)) |->
        (p0_rise == $past(in_samples[0 +: W]) && p1_rise == $past(in_samples[W +: W]) &&
         p0_fall == $past(in_samples[2*W +: W]) && p1_fall == $past(in_samples[3*W +: W]))); // R2

    AST_MSB_FLIP: assert property (@(posedge clk) disable iff (!rst_n || !init_done)
        ($past(rst_n) && $past(in_valid) && $past(cfg_twos)) |->
        (p0_rise[W-1] != $past(in_samples[W-1]) &&
         p0_rise[W-2:0] == $past(in_samples[W-2:0]))); // R4

    AST_IDLE_MID: assert property (@(posedge clk) disable iff (!rst_n || !init_done)
        ($past(rst_n) && !$past(in_valid)) |->
        (p0_rise == MID && p0_fall == MID && p1_rise == MID && p1_fall == MID)); // R6

    AST_LANE_PATTERN: assert property (@(posedge clk) disable iff (!init_done)
        init_done |=> (clk_rise && !clk_fall)); // R7
endmodule

bind dac_ddr_fmt dfmt_chk #(.W(W)) u_dfmt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .cfg_twos   (cfg_twos),
    .in_samples (in_samples),
    .p0_rise    (p0_rise),
    .p0_fall    (p0_fall),
    .p1_rise    (p1_rise),
    .p1_fall    (p1_fall),
    .clk_rise   (clk_rise),
    .clk_fall   (clk_fall)
);

// File: tb/test_dac_ddr_fmt.sv
// Bench for dac_ddr_fmt: random stimulus from a fixed seed plus directed corner cases.
module test_dac_ddr_fmt;
    localparam int W = 14;
    localparam logic [W-1:0] MID  = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MASK = {W{1'b1}};

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           cfg_twos = 1'b0;
    logic [4*W-1:0] in_samples = '0;
    logic [W-1:0]   p0_rise, p0_fall, p1_rise, p1_fall;
    logic           clk_rise, clk_fall;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    dac_ddr_fmt #(.W(W)) i_dac_ddr_fmt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_twos(cfg_twos),
        .in_samples(in_samples), .p0_rise(p0_rise), .p0_fall(p0_fall),
        .p1_rise(p1_rise), .p1_fall(p1_fall), .clk_rise(clk_rise), .clk_fall(clk_fall)
    );

    always #4 clk = ~clk;

    // Expected word, derived from R1, R4, R5 and R6.
    function automatic logic [W-1:0] exp_word(logic [W-1:0] s, logic v, logic tw, logic r);
        if (!r || !v) return MID;
        return tw ? (s ^ MID) : s;
    endfunction

    task automatic cmp(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Applies one cycle of stimulus at the falling edge and checks after the next rising edge (R3).
    task automatic step(logic r, logic v, logic tw, logic [W-1:0] s0, logic [W-1:0] s1,
                        logic [W-1:0] s2, logic [W-1:0] s3, string req);
        rst_n = r; in_valid = v; cfg_twos = tw;
        in_samples = {s3, s2, s1, s0};
        @(posedge clk);
        @(negedge clk);
        cmp({req, " R2 R3 p0_rise"}, p0_rise, exp_word(s0, v, tw, r));
        cmp({req, " R2 R3 p1_rise"}, p1_rise, exp_word(s1, v, tw, r));
        cmp({req, " R2 R3 p0_fall"}, p0_fall, exp_word(s2, v, tw, r));
        cmp({req, " R2 R3 p1_fall"}, p1_fall, exp_word(s3, v, tw, r));
        cmp("R7 clk_rise", {{(W-1){1'b0}}, clk_rise}, 1);
        cmp("R7 clk_fall", {{(W-1){1'b0}}, clk_fall}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset with active data must still produce mid-scale.
        step(0, 1, 1, 14'h1234, 14'h0abc, 14'h3fff, 14'h0001, "R1");
        step(0, 1, 0, 14'h0000, 14'h3fff, 14'h2000, 14'h1fff, "R1");
        // R5: pass-through corner cases.
        step(1, 1, 0, 14'h0000, 14'h3fff, 14'h2000, 14'h1fff, "R5");
        // R4: two's complement extremes.
        step(1, 1, 1, 14'h2000, 14'h1fff, 14'h0000, 14'h3fff, "R4");
        // R6: idle with conversion on and off.
        step(1, 0, 1, 14'h0123, 14'h0456, 14'h0789, 14'h0abc, "R6");
        step(1, 0, 0, 14'h3fff, 14'h3fff, 14'h3fff, 14'h3fff, "R6");
        // R2: distinct samples in every position.
        step(1, 1, 0, 14'h0001, 14'h0002, 14'h0004, 14'h0008, "R2");
        for (int k = 0; k < 400; k++) begin
            logic r, v, tw;
            r  = ($urandom % 16) != 0;
            v  = ($urandom % 4) != 0;
            tw = $urandom % 2;
            step(r, v, tw, W'($urandom) & MASK, W'($urandom) & MASK,
                 W'($urandom) & MASK, W'($urandom) & MASK, "RND R4 R5 R6");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule